// File: doc/BRIEF.md
# Decoder Control and Status Registers

This block is the processor-facing register set of a bitstream decoding engine. It collects one-cycle event pulses from the decoding datapath into seven sticky status flags and masks them with a per-flag enable register to drive one interrupt line. A control register holds an 8-bit slice code and an input-done mode bit. The slice code is loaded either by the datapath when it finds a new slice or by software between commands. After a restart, the datapath patches the slice code into the first macroblock header it emits.

A small engine tracker follows the command lifecycle, so the block knows when the engine is active. It has three states. ST_IDLE moves to ST_RUN on `cmd_issue`. ST_RUN moves to ST_HALT when a start code, bitstream error or overflow pulse arrives; this takes priority over completion. ST_RUN otherwise moves to ST_IDLE on `ev_cmd_done`. ST_HALT moves back to ST_RUN on `cmd_issue`, and that transition is a restart. A `cmd_issue` seen in ST_RUN changes nothing. The engine counts as active only in ST_RUN.

Registers are written on the rising clock edge. Read data is a combinational function of `reg_addr`. The address map is: 0 status, 1 interrupt enable, 2 control.

Top module: `dec_csr_top`

## Requirements
- R1: After synchronous reset, the status, enable and control registers read 0, `irq` is 0 and `hdr_word_out` equals `hdr_word_in`.
- R2: Status bits, in order from bit 0: command done, start code seen, bitstream error, input done, header output done, run/level output done, run/level overflow. Each bit is set by its event pulse and holds until it is cleared.
- R3: Writing status with a 1 in bit 1, 2, 3 or 6 clears that flag. A 0 in those bits leaves the flag as it was.
- R4: Bits 0, 4 and 5 ignore status writes and clear only when `cmd_issue` is pulsed.
- R5: When a set pulse and a clear land on the same flag in the same cycle, the flag ends set.
- R6: The start-code flag sets only if its pulse arrives while the engine is in ST_RUN.
- R7: The enable register (address 1, bits 6:0) is read/write. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R8: A `slice_hit` pulse loads `slice_code_in` into control bits 7:0, whatever the engine state.
- R9: A control write with bit 8 set changes only the slice code (bits 7:0). A write with bit 8 clear changes only the mode bit (bit 12). Bit 8 always reads 0.
- R10: A software slice-code write is ignored while the engine is in ST_RUN.
- R11: The engine tracker follows the transitions given above. ST_IDLE and ST_HALT both count as inactive.
- R12: From a restart until `hdr_take`, `hdr_word_out` is `hdr_word_in` with bits 23:16 replaced by the slice code and bit 0 forced to 1. At all other times it passes `hdr_word_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cmd_issue | input | 1 | New command or restart pulse |
| ev_cmd_done | input | 1 | Command completed pulse |
| ev_start_code | input | 1 | Start code found pulse |
| ev_bs_err | input | 1 | Illegal code or unexpected start code pulse |
| ev_in_done | input | 1 | Input transfer done pulse |
| ev_hdr_done | input | 1 | Header output transfer done pulse |
| ev_rl_done | input | 1 | Run/level output transfer done pulse |
| ev_rl_ovf | input | 1 | Run/level overflow pulse |
| slice_hit | input | 1 | New slice found; load `slice_code_in` |
| slice_code_in | input | 8 | Low byte of the slice start code |
| hdr_take | input | 1 | First header after restart consumed |
| hdr_word_in | input | 32 | Last word of the outgoing macroblock header |
| hdr_word_out | output | 32 | Header word, patched after a restart |
| slice_code | output | 8 | Stored slice code |
| done_mode | output | 1 | Input-done mode bit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are those that depend on the engine tracker's hidden state. These are the gated start-code flag, the ignored slice-code write and the header patch, which appears only on the ST_HALT to ST_RUN transition. The stimulus walks the tracker through every transition with command, completion, start-code and overflow pulses. At each stop it probes these behaviours, so the state is inferred purely from register contents and the header output. The set-versus-clear collision is produced by issuing a status write and an error pulse in the same cycle.

// File: rtl/dec_csr_pkg.sv
package dec_csr_pkg;
    localparam int NUM_FLAGS = 7;

    localparam int F_CMD_DONE = 0;
    localparam int F_START    = 1;
    localparam int F_BS_ERR   = 2;
    localparam int F_IN_DONE  = 3;
    localparam int F_HDR_DONE = 4;
    localparam int F_RL_DONE  = 5;
    localparam int F_RL_OVF   = 6;

    // flags cleared by software write-1; the rest clear on a new command
    localparam logic [NUM_FLAGS-1:0] W1C_MASK = 7'b100_1110;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_IE     = 2'd1;
    localparam logic [1:0] ADDR_CTL    = 2'd2;

    localparam int CTL_STROBE_BIT = 8;
    localparam int CTL_MODE_BIT   = 12;
    localparam int HDR_CODE_LSB   = 16;
    localparam int HDR_FIRST_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/dec_csr_fsm.sv
module dec_csr_fsm
    import dec_csr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_issue,
    input  logic ev_done,
    input  logic ev_halt,
    output logic active,
    output logic restart
);
    eng_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_issue) state_d = ST_RUN;
            ST_RUN: begin
                if (ev_halt)      state_d = ST_HALT;
                else if (ev_done) state_d = ST_IDLE;
            end
            ST_HALT: if (cmd_issue) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active  = (state_q == ST_RUN);
        restart = cmd_issue && (state_q == ST_HALT);
    end

    AST_RUN_TO_HALT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && ev_halt) |=> (state_q == ST_HALT)); // R11
    AST_RUN_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && ev_done && !ev_halt) |=> (state_q == ST_IDLE)); // R11
    AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (rst)
        restart |=> active); // R11
endmodule

// File: rtl/dec_csr_status.sv
module dec_csr_status
    import dec_csr_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic         cmd_clr_i,
    input  logic         ie_we,
    input  logic [N-1:0] ie_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] ie,
    output logic         irq
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic clr;
        if (W1C_MASK[g]) begin : g_w1c
            assign clr = w1c_i[g];
            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (w1c_i[g] && !set_i[g]) |=> !flags[g]); // R3
        end else begin : g_cmdclr
            assign clr = cmd_clr_i;
            AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (cmd_clr_i && !set_i[g]) |=> !flags[g]); // R4
            AST_W1C_IGNORED: assert property (@(posedge clk) disable iff (rst)
                (flags[g] && !cmd_clr_i) |=> flags[g]); // R4
        end

        always_ff @(posedge clk) begin
            if (rst)           flags[g] <= 1'b0;
            else if (set_i[g]) flags[g] <= 1'b1;
            else if (clr)      flags[g] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> flags[g]); // R5
    end

    always_ff @(posedge clk) begin
        if (rst)        ie <= '0;
        else if (ie_we) ie <= ie_wdata;
    end

    always_comb irq = |(flags & ie);
endmodule

// File: rtl/dec_csr_ctl.sv
module dec_csr_ctl
    import dec_csr_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    input  logic              slice_hit,
    input  logic [CODE_W-1:0] slice_code_in,
    input  logic              restart,
    input  logic              hdr_take,
    input  logic [DATA_W-1:0] hdr_word_in,
    output logic [DATA_W-1:0] hdr_word_out,
    output logic [CODE_W-1:0] slice_code,
    output logic              done_mode,
    output logic [DATA_W-1:0] ctl_rdata
);
    logic strobe;
    logic first_pend;
    logic unused_wdata;

    assign strobe       = wdata[CTL_STROBE_BIT];
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst)                             slice_code <= '0;
        else if (slice_hit)                  slice_code <= slice_code_in;
        else if (ctl_we && strobe && !active) slice_code <= wdata[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                   done_mode <= 1'b0;
        else if (ctl_we && !strobe) done_mode <= wdata[CTL_MODE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)           first_pend <= 1'b0;
        else if (restart)  first_pend <= 1'b1;
        else if (hdr_take) first_pend <= 1'b0;
    end

    always_comb begin
        hdr_word_out = hdr_word_in;
        if (first_pend) begin
            hdr_word_out[HDR_CODE_LSB +: CODE_W] = slice_code;
            hdr_word_out[HDR_FIRST_BIT]          = 1'b1;
        end
    end

    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[CODE_W-1:0]    = slice_code;
        ctl_rdata[CTL_MODE_BIT]  = done_mode;
    end

    AST_SLICE_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (active && !slice_hit) |=> $stable(slice_code)); // R10
    AST_STROBE_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && strobe) |=> $stable(done_mode)); // R9
    AST_MODE_KEEPS_SLICE: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !strobe && !slice_hit) |=> $stable(slice_code)); // R9
    AST_RESTART_PATCH: assert property (@(posedge clk) disable iff (rst)
        restart |=> hdr_word_out[HDR_FIRST_BIT]); // R12
    AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (rst)
        slice_hit |=> (slice_code == $past(slice_code_in))); // R8
endmodule

// File: rtl/dec_csr_top.sv
module dec_csr_top
    import dec_csr_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmd_issue,
    input  logic              ev_cmd_done,
    input  logic              ev_start_code,
    input  logic              ev_bs_err,
    input  logic              ev_in_done,
    input  logic              ev_hdr_done,
    input  logic              ev_rl_done,
    input  logic              ev_rl_ovf,
    input  logic              slice_hit,
    input  logic [CODE_W-1:0] slice_code_in,
    input  logic              hdr_take,
    input  logic [DATA_W-1:0] hdr_word_in,
    output logic [DATA_W-1:0] hdr_word_out,
    output logic [CODE_W-1:0] slice_code,
    output logic              done_mode,
    output logic              irq
);
    localparam int N = NUM_FLAGS;

    logic              active, restart;
    logic [N-1:0]      set_v, w1c_v, flags, ie;
    logic              st_we, ie_we, ctl_we;
    logic [DATA_W-1:0] ctl_rdata;

    assign st_we  = reg_we && (reg_addr == ADDR_W'(ADDR_STATUS));
    assign ie_we  = reg_we && (reg_addr == ADDR_W'(ADDR_IE));
    assign ctl_we = reg_we && (reg_addr == ADDR_W'(ADDR_CTL));

    always_comb begin
        set_v             = '0;
        set_v[F_CMD_DONE] = ev_cmd_done;
        set_v[F_START]    = ev_start_code && active;
        set_v[F_BS_ERR]   = ev_bs_err;
        set_v[F_IN_DONE]  = ev_in_done;
        set_v[F_HDR_DONE] = ev_hdr_done;
        set_v[F_RL_DONE]  = ev_rl_done;
        set_v[F_RL_OVF]   = ev_rl_ovf;
        w1c_v             = st_we ? (reg_wdata[N-1:0] & W1C_MASK) : '0;
    end

    dec_csr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_issue (cmd_issue),
        .ev_done   (ev_cmd_done),
        .ev_halt   (ev_start_code | ev_bs_err | ev_rl_ovf),
        .active    (active),
        .restart   (restart)
    );

    dec_csr_status #(.N(N)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_v),
        .w1c_i     (w1c_v),
        .cmd_clr_i (cmd_issue),
        .ie_we     (ie_we),
        .ie_wdata  (reg_wdata[N-1:0]),
        .flags     (flags),
        .ie        (ie),
        .irq       (irq)
    );

    dec_csr_ctl #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_ctl (
        .clk           (clk),
        .rst           (rst),
        .ctl_we        (ctl_we),
        .wdata         (reg_wdata),
        .active        (active),
        .slice_hit     (slice_hit),
        .slice_code_in (slice_code_in),
        .restart       (restart),
        .hdr_take      (hdr_take),
        .hdr_word_in   (hdr_word_in),
        .hdr_word_out  (hdr_word_out),
        .slice_code    (slice_code),
        .done_mode     (done_mode),
        .ctl_rdata     (ctl_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(ADDR_STATUS): reg_rdata[N-1:0] = flags;
            ADDR_W'(ADDR_IE):     reg_rdata[N-1:0] = ie;
            ADDR_W'(ADDR_CTL):    reg_rdata        = ctl_rdata;
            default:              reg_rdata        = '0;
        endcase
    end

    AST_GATED_START: assert property (@(posedge clk) disable iff (rst)
        (!active && ev_start_code && !flags[F_START]) |=> !flags[F_START]); // R6
    AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> !irq); // R7
endmodule

// File: tb/test_dec_csr_top.sv
`timescale 1ns/1ps
module test_dec_csr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_issue = 1'b0;
    logic [6:0]  ev = '0;
    logic        slice_hit = 1'b0;
    logic [7:0]  slice_code_in = '0;
    logic        hdr_take = 1'b0;
    logic [31:0] hdr_word_in = 32'h1234_5678;
    logic [31:0] hdr_word_out;
    logic [7:0]  slice_code;
    logic        done_mode;
    logic        irq;

    dec_csr_top i_dec_csr_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_issue(cmd_issue),
        .ev_cmd_done(ev[0]), .ev_start_code(ev[1]), .ev_bs_err(ev[2]),
        .ev_in_done(ev[3]), .ev_hdr_done(ev[4]), .ev_rl_done(ev[5]),
        .ev_rl_ovf(ev[6]), .slice_hit(slice_hit), .slice_code_in(slice_code_in),
        .hdr_take(hdr_take), .hdr_word_in(hdr_word_in), .hdr_word_out(hdr_word_out),
        .slice_code(slice_code), .done_mode(done_mode), .irq(irq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    event        sample_ev;

    int          m_kind;
    logic [31:0] m_exp, m_act;
    string       m_tag;

    // monitor: pops expected items and compares against the ports
    initial forever begin
        @(sample_ev);
        while (q_kind.size() > 0) begin
            m_kind = q_kind.pop_front();
            m_exp  = q_exp.pop_front();
            m_tag  = q_tag.pop_front();
            case (m_kind)
                0:       m_act = reg_rdata;
                1:       m_act = {31'b0, irq};
                2:       m_act = hdr_word_out;
                default: m_act = {31'b0, done_mode};
            endcase
            checks++;
            if (m_act !== m_exp) begin
                fails++;
                $display("FAIL %s: actual=%h expected=%h", m_tag, m_act, m_exp);
            end
        end
    end

    task automatic expect_item(int kind, logic [31:0] exp, string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        #1;
        ->sample_ev;
        #1;
    endtask

    task automatic exp_rd(logic [1:0] ad, logic [31:0] exp, string tag);
        reg_addr = ad;
        expect_item(0, exp, tag);
    endtask

    task automatic drive(logic we, logic [1:0] ad, logic [31:0] d, logic cmd,
                         logic [6:0] e, logic sh, logic [7:0] sc, logic take);
        @(negedge clk);
        reg_we = we; reg_addr = ad; reg_wdata = d; cmd_issue = cmd;
        ev = e; slice_hit = sh; slice_code_in = sc; hdr_take = take;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; cmd_issue = 1'b0;
        ev = '0; slice_hit = 1'b0; hdr_take = 1'b0;
    endtask

    task automatic wr(logic [1:0] ad, logic [31:0] d);
        drive(1'b1, ad, d, 1'b0, 7'h00, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic evp(logic cmd, logic [6:0] e);
        drive(1'b0, 2'd0, 32'h0, cmd, e, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        exp_rd(2'd0, 32'h0, "R1 status");
        exp_rd(2'd1, 32'h0, "R1 enable");
        exp_rd(2'd2, 32'h0, "R1 control");
        expect_item(1, 32'h0, "R1 irq");
        expect_item(2, 32'h1234_5678, "R1 hdr passthrough");

        // R2 R6: all pulses in ST_IDLE, start-code flag gated off
        evp(1'b0, 7'h7F);
        exp_rd(2'd0, 32'h7D, "R2 R6 flags set in idle");
        expect_item(1, 32'h0, "R7 no irq with enables clear");

        // R7 enable
        wr(2'd1, 32'h04);
        exp_rd(2'd1, 32'h04, "R7 enable readback");
        expect_item(1, 32'h1, "R7 irq on enabled flag");

        // R3 R4 write-1 clears only bits 1,2,3,6
        wr(2'd0, 32'h7F);
        exp_rd(2'd0, 32'h31, "R3 R4 write-1 clear");
        expect_item(1, 32'h0, "R7 irq drops");
        wr(2'd0, 32'h00);
        exp_rd(2'd0, 32'h31, "R3 write-0 no effect");

        // R4 new command clears bits 0,4,5; enter ST_RUN
        evp(1'b1, 7'h00);
        exp_rd(2'd0, 32'h00, "R4 cmd clears");

        // R6 R11 start code in ST_RUN sets flag, halts
        evp(1'b0, 7'h02);
        exp_rd(2'd0, 32'h02, "R6 start code in run");

        // R5 set wins over clear
        drive(1'b1, 2'd0, 32'h04, 1'b0, 7'h04, 1'b0, 8'h00, 1'b0);
        exp_rd(2'd0, 32'h06, "R5 set wins");
        expect_item(1, 32'h1, "R7 irq with error flag");

        // R8 slice latch
        drive(1'b0, 2'd0, 32'h0, 1'b0, 7'h00, 1'b1, 8'hA5, 1'b0);
        exp_rd(2'd2, 32'hA5, "R8 slice latched");

        // R9 strobe write in ST_HALT
        wr(2'd2, 32'h0000_113C);
        exp_rd(2'd2, 32'h3C, "R9 strobe updates code only, bit8 reads 0");
        wr(2'd2, 32'h0000_10FF);
        exp_rd(2'd2, 32'h103C, "R9 mode write keeps code");
        expect_item(3, 32'h1, "R9 done_mode port");

        // R12 restart patch
        expect_item(2, 32'h1234_5678, "R12 no patch before restart");
        evp(1'b1, 7'h00);
        expect_item(2, 32'h123C_5679, "R12 patched after restart");
        exp_rd(2'd0, 32'h06, "R4 restart keeps w1c flags");
        drive(1'b0, 2'd0, 32'h0, 1'b0, 7'h00, 1'b0, 8'h00, 1'b1);
        expect_item(2, 32'h1234_5678, "R12 patch ends on take");

        // R10 slice write ignored in ST_RUN
        wr(2'd2, 32'h0000_0199);
        exp_rd(2'd2, 32'h103C, "R10 code write ignored while running");
        wr(2'd2, 32'h0000_0000);
        exp_rd(2'd2, 32'h003C, "R9 mode write while running");

        // R11 run -> idle on completion, slice write accepted
        evp(1'b0, 7'h01);
        exp_rd(2'd0, 32'h07, "R2 command done");
        wr(2'd2, 32'h0000_0199);
        exp_rd(2'd2, 32'h99, "R11 idle accepts code write");

        // R6 start code in ST_IDLE ignored
        wr(2'd0, 32'h02);
        exp_rd(2'd0, 32'h05, "R3 clear start flag");
        evp(1'b0, 7'h02);
        exp_rd(2'd0, 32'h05, "R6 start code in idle ignored");

        // R11 run -> halt on overflow
        evp(1'b1, 7'h00);
        exp_rd(2'd0, 32'h04, "R4 cmd clears done");
        evp(1'b0, 7'h40);
        exp_rd(2'd0, 32'h44, "R2 overflow flag");
        wr(2'd2, 32'h0000_01AB);
        exp_rd(2'd2, 32'hAB, "R11 halt accepts code write");

        // R7 enable masking
        wr(2'd1, 32'h40);
        exp_rd(2'd1, 32'h40, "R7 enable readback 2");
        expect_item(1, 32'h1, "R7 irq from overflow");
        wr(2'd1, 32'h00);
        expect_item(1, 32'h0, "R7 irq masked");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule